// File: doc/BRIEF.md
# XTS Tweak Sequencer

This block produces the stream of per-block tweak values used by XTS-AES storage encryption. A session is started with a starting sector index, a sector size in bytes and a number of sectors. For each sector, the sequencer sends the sector index to an external tweak-encryption engine. That engine holds the already expanded tweak key. The sequencer takes back the encrypted result as the sector's first tweak. It then streams one 128-bit tweak per 16-byte data block, doubling the value in GF(2^128) between blocks.

The sector index arrives in byte-reversed (big-endian) form. It is swapped to a numeric value and zero-extended to 128 bits before it is issued. The index advances by one at every sector boundary of a multi-sector session, and every sector gets a fresh request. Each emitted tweak is tagged with flags for the first and the last block of its sector. A single-cycle done pulse closes the session. An illegal size/count combination raises a single-cycle error pulse, and nothing is issued.

Top module: `xts_tweak_seq`

## Requirements
- R1: After reset, `treq_valid_o`, `tw_valid_o`, `done_o`, `err_o` and `busy_o` are all low.
- R2: The tweak request carries the numeric sector index in bits 63:0 and zeros in bits 127:64. The index is obtained by byte-reversing `idx_be_i`: the index's least significant byte sits at `idx_be_i[63:56]`. The request and its data are held until `treq_ready_i` is seen high.
- R3: The first tweak of every sector equals the `tresp_data_i` value captured on the cycle `tresp_valid_i` was high. No tweak is offered before that response.
- R4: Each further tweak in a sector is the previous tweak shifted left by one bit. When bit 127 of the previous tweak was 1, the low byte is also XORed with 0x87.
- R5: A sector yields ceil(bytes/16) tweaks. `tw_first_o` is high on the first of them only, and `tw_last_o` on the last only.
- R6: While `tw_valid_o` is high and `tw_ready_i` is low, the tweak and its flags stay unchanged. The value advances only on an accepted transfer.
- R7: In a multi-sector session, the index sent for sector n is the start index plus n. Each sector issues exactly one request, and its block numbering restarts at the first-block flag.
- R8: A start is rejected with a one-cycle `err_o` pulse and no request in three cases: a zero size, a zero count, or a size that is not a multiple of 16 with a count above one.
- R9: `done_o` pulses for one cycle on the cycle after the last tweak of the last sector is accepted, with `busy_o` low. A `start_i` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a session (sampled when idle) |
| idx_be_i | input | 64 | Starting sector index, byte-reversed |
| sec_bytes_i | input | SZ_W | Sector size in bytes |
| sec_cnt_i | input | CNT_W | Number of sectors |
| busy_o | output | 1 | Session in progress |
| err_o | output | 1 | One-cycle pulse: start rejected |
| done_o | output | 1 | One-cycle pulse: session finished |
| treq_valid_o | output | 1 | Tweak-encryption request valid |
| treq_data_o | output | 128 | Zero-extended sector index |
| treq_ready_i | input | 1 | Request accepted |
| tresp_valid_i | input | 1 | Encrypted tweak valid |
| tresp_data_i | input | 128 | Encrypted tweak |
| tw_valid_o | output | 1 | Tweak output valid |
| tw_data_o | output | 128 | Tweak value |
| tw_first_o | output | 1 | First block of sector |
| tw_last_o | output | 1 | Last block of sector |
| tw_ready_i | input | 1 | Tweak output accepted |

## Verification
The checker assumes that the tweak engine returns exactly one response per accepted request, and only while the sequencer waits for it. It also assumes that `start_i` parameters are valid only on the start cycle. The bench plays the engine itself: it pulses `tresp_valid_i` once after each request handshake, with a random delay, and never otherwise. It applies random back-pressure on both handshakes, and it drives a start pulse with altered parameters during a session to probe R9.

// File: rtl/xts_tweak_pkg.sv
package xts_tweak_pkg;
  localparam int TW_W   = 128;
  localparam int IDX_W  = 64;
  localparam int BLK_SH = 4; // log2 of 16-byte data block
  localparam logic [7:0] GF_RED = 8'h87;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_EMIT} seq_st_e;

  function automatic logic [TW_W-1:0] gf_dbl(input logic [TW_W-1:0] v);
    logic [TW_W-1:0] r;
    r = {v[TW_W-2:0], 1'b0};
    if (v[TW_W-1]) r[7:0] = r[7:0] ^ GF_RED;
    return r;
  endfunction
endpackage

// File: rtl/xts_idx_swap.sv
module xts_idx_swap #(
  parameter int NBYTES = 8
) (
  input  logic [8*NBYTES-1:0] be_i,
  output logic [8*NBYTES-1:0] val_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign val_o[8*g +: 8] = be_i[8*(NBYTES-1-g) +: 8];
  end
endmodule

// File: rtl/xts_gf_dbl.sv
module xts_gf_dbl #(
  parameter int         W   = 128,
  parameter logic [7:0] RED = 8'h87
) (
  input  logic [W-1:0] v_i,
  output logic [W-1:0] v_o
);
  logic [W-1:0] red_w;
  assign red_w = {{(W-8){1'b0}}, RED};
  assign v_o   = {v_i[W-2:0], 1'b0} ^ (v_i[W-1] ? red_w : '0);
endmodule

// File: rtl/xts_blk_ctr.sv
module xts_blk_ctr #(
  parameter int BLK_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [BLK_W-1:0] nblk_i,
  output logic             first_o,
  output logic             last_o
);
  logic [BLK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == nblk_i - 1'b1);
endmodule

// File: rtl/xts_tweak_seq.sv
module xts_tweak_seq
  import xts_tweak_pkg::*;
#(
  parameter int SZ_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   idx_be_i,
  input  logic [SZ_W-1:0]    sec_bytes_i,
  input  logic [CNT_W-1:0]   sec_cnt_i,
  output logic               busy_o,
  output logic               err_o,
  output logic               done_o,
  output logic               treq_valid_o,
  output logic [TW_W-1:0]    treq_data_o,
  input  logic               treq_ready_i,
  input  logic               tresp_valid_i,
  input  logic [TW_W-1:0]    tresp_data_i,
  output logic               tw_valid_o,
  output logic [TW_W-1:0]    tw_data_o,
  output logic               tw_first_o,
  output logic               tw_last_o,
  input  logic               tw_ready_i
);
  localparam int BLK_W = SZ_W - BLK_SH + 1;

  seq_st_e          st_q;
  logic [IDX_W-1:0] idx_q, idx_sw;
  logic [BLK_W-1:0] nblk_q, nblk_calc;
  logic [CNT_W-1:0] left_q;
  logic [TW_W-1:0]  tw_q, tw_nxt;
  logic             err_q, done_q;
  logic             partial, bad_cfg, start_ok;
  logic             tw_hs, blk_first, blk_last, last_sec;

  xts_idx_swap #(.NBYTES(IDX_W/8)) u_swap (.be_i(idx_be_i), .val_o(idx_sw));

  xts_gf_dbl #(.W(TW_W), .RED(GF_RED)) u_dbl (.v_i(tw_q), .v_o(tw_nxt));

  assign partial   = |sec_bytes_i[BLK_SH-1:0];
  assign nblk_calc = {1'b0, sec_bytes_i[SZ_W-1:BLK_SH]} + BLK_W'(partial);
  assign bad_cfg   = (sec_bytes_i == '0) || (sec_cnt_i == '0) ||
                     (partial && (sec_cnt_i != CNT_W'(1)));
  assign start_ok  = (st_q == ST_IDLE) && start_i && !bad_cfg;

  assign tw_hs    = (st_q == ST_EMIT) && tw_ready_i;
  assign last_sec = (left_q == CNT_W'(1));

  xts_blk_ctr #(.BLK_W(BLK_W)) u_blk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   ((st_q == ST_WAIT) && tresp_valid_i),
    .adv_i   (tw_hs),
    .nblk_i  (nblk_q),
    .first_o (blk_first),
    .last_o  (blk_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      nblk_q <= '0;
      left_q <= '0;
      tw_q   <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      err_q  <= (st_q == ST_IDLE) && start_i && bad_cfg;
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_ok) begin
          idx_q  <= idx_sw;
          nblk_q <= nblk_calc;
          left_q <= sec_cnt_i;
          st_q   <= ST_REQ;
        end
        ST_REQ: if (treq_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (tresp_valid_i) begin
          tw_q <= tresp_data_i;
          st_q <= ST_EMIT;
        end
        ST_EMIT: if (tw_hs) begin
          if (!blk_last) begin
            tw_q <= tw_nxt;
          end else if (last_sec) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            idx_q  <= idx_q + 1'b1;
            left_q <= left_q - 1'b1;
            st_q   <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign err_o        = err_q;
  assign done_o       = done_q;
  assign treq_valid_o = (st_q == ST_REQ);
  assign treq_data_o  = {{(TW_W-IDX_W){1'b0}}, idx_q};
  assign tw_valid_o   = (st_q == ST_EMIT);
  assign tw_data_o    = tw_q;
  assign tw_first_o   = (st_q == ST_EMIT) && blk_first;
  assign tw_last_o    = (st_q == ST_EMIT) && blk_last;
endmodule

// File: rtl/xts_tweak_seq_chk.sv
module xts_tweak_seq_chk
  import xts_tweak_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            err_o,
  input logic            done_o,
  input logic            treq_valid_o,
  input logic [TW_W-1:0] treq_data_o,
  input logic            treq_ready_i,
  input logic            tw_valid_o,
  input logic [TW_W-1:0] tw_data_o,
  input logic            tw_first_o,
  input logic            tw_last_o,
  input logic            tw_ready_i
);
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    treq_valid_o && !treq_ready_i |=> treq_valid_o && $stable(treq_data_o));

  p_req_zext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    treq_valid_o |-> treq_data_o[TW_W-1:IDX_W] == '0);

  p_dbl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tw_valid_o && tw_ready_i && !tw_last_o |=>
      tw_valid_o && !tw_first_o && (tw_data_o == gf_dbl($past(tw_data_o))));

  p_tw_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tw_valid_o && !tw_ready_i |=>
      tw_valid_o && $stable(tw_data_o) && $stable(tw_first_o) && $stable(tw_last_o));

  p_one_side_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({treq_valid_o, tw_valid_o}));

  p_err_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !treq_valid_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o ##1 !done_o);

  p_done_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(tw_valid_o && tw_ready_i && tw_last_o));
endmodule

bind xts_tweak_seq xts_tweak_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .err_o        (err_o),
  .done_o       (done_o),
  .treq_valid_o (treq_valid_o),
  .treq_data_o  (treq_data_o),
  .treq_ready_i (treq_ready_i),
  .tw_valid_o   (tw_valid_o),
  .tw_data_o    (tw_data_o),
  .tw_first_o   (tw_first_o),
  .tw_last_o    (tw_last_o),
  .tw_ready_i   (tw_ready_i)
);

// File: tb/xts_tweak_seq_tb.sv
module xts_tweak_seq_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [63:0]  idx_be_i = '0;
  logic [15:0]  sec_bytes_i = '0;
  logic [15:0]  sec_cnt_i = '0;
  logic         busy_o, err_o, done_o;
  logic         treq_valid_o, treq_ready_i = 1'b0;
  logic [127:0] treq_data_o;
  logic         tresp_valid_i = 1'b0;
  logic [127:0] tresp_data_i = '0;
  logic         tw_valid_o, tw_first_o, tw_last_o, tw_ready_i = 1'b0;
  logic [127:0] tw_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  xts_tweak_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .idx_be_i(idx_be_i),
    .sec_bytes_i(sec_bytes_i), .sec_cnt_i(sec_cnt_i), .busy_o(busy_o),
    .err_o(err_o), .done_o(done_o), .treq_valid_o(treq_valid_o),
    .treq_data_o(treq_data_o), .treq_ready_i(treq_ready_i),
    .tresp_valid_i(tresp_valid_i), .tresp_data_i(tresp_data_i),
    .tw_valid_o(tw_valid_o), .tw_data_o(tw_data_o), .tw_first_o(tw_first_o),
    .tw_last_o(tw_last_o), .tw_ready_i(tw_ready_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] swap64(input logic [63:0] b);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = b[8*(7-k) +: 8];
    return r;
  endfunction

  function automatic logic [127:0] ref_dbl(input logic [127:0] v);
    logic [127:0] r;
    r = v << 1;
    if (v[127]) r = r ^ 128'h87;
    return r;
  endfunction

  function automatic logic [127:0] fake_enc(input logic [63:0] x);
    return {x * 64'h9E3779B97F4A7C15 ^ 64'hD1B54A32D192ED03,
            (x ^ 64'h5DEECE66D) * 64'hBF58476D1CE4E5B9};
  endfunction

  task automatic run_session(input logic [63:0] ibe, input int bytes,
                             input int cnt, input bit poke);
    logic [63:0]  iv;
    logic [127:0] ex, req_exp, hold;
    int nb;
    iv = swap64(ibe);
    nb = (bytes + 15) / 16;
    @(negedge clk);
    idx_be_i = ibe; sec_bytes_i = bytes[15:0]; sec_cnt_i = cnt[15:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R9 busy after start", 128'(busy_o), 128'd1);
    for (int s = 0; s < cnt; s++) begin
      for (int t = 0; t < 50 && !treq_valid_o; t++) @(negedge clk);
      req_exp = {64'd0, iv + 64'(s)};
      chk(treq_valid_o && treq_data_o == req_exp, "R2 R7 request index", treq_data_o, req_exp);
      for (int k = $urandom_range(0, 2); k > 0; k--) begin
        @(negedge clk);
        chk(treq_valid_o && treq_data_o == req_exp, "R2 request held", treq_data_o, req_exp);
      end
      treq_ready_i = 1'b1;
      @(negedge clk);
      treq_ready_i = 1'b0;
      for (int k = $urandom_range(0, 3); k > 0; k--) @(negedge clk);
      chk(!tw_valid_o, "R3 no tweak before response", 128'(tw_valid_o), 128'd0);
      ex = fake_enc(iv + 64'(s));
      tresp_valid_i = 1'b1; tresp_data_i = ex;
      @(negedge clk);
      tresp_valid_i = 1'b0; tresp_data_i = {$urandom, $urandom, $urandom, $urandom};
      for (int b = 0; b < nb; b++) begin
        for (int t = 0; t < 50 && !tw_valid_o; t++) @(negedge clk);
        chk(tw_valid_o && tw_data_o == ex, b == 0 ? "R3 first tweak" : "R4 doubled tweak",
            tw_data_o, ex);
        chk(tw_first_o == (b == 0) && tw_last_o == (b == nb - 1), "R5 R7 first/last flags",
            128'({tw_first_o, tw_last_o}), 128'({b == 0, b == nb - 1}));
        hold = tw_data_o;
        if (poke && s == 0 && b == 1) begin
          start_i = 1'b1; idx_be_i = ~ibe; sec_cnt_i = 16'd1; sec_bytes_i = 16'd16;
          @(negedge clk);
          start_i = 1'b0;
          chk(tw_valid_o && tw_data_o == hold, "R9 start ignored while busy", tw_data_o, hold);
        end
        for (int k = $urandom_range(0, 2); k > 0; k--) begin
          @(negedge clk);
          chk(tw_valid_o && tw_data_o == hold, "R6 stall holds tweak", tw_data_o, hold);
        end
        tw_ready_i = 1'b1;
        @(negedge clk);
        tw_ready_i = 1'b0;
        ex = ref_dbl(ex);
      end
      chk(!tw_valid_o, "R5 no extra block", 128'(tw_valid_o), 128'd0);
      if (s == cnt - 1)
        chk(done_o && !busy_o, "R9 done after last block", 128'({done_o, busy_o}), 128'b10);
      else
        chk(!done_o, "R9 no done mid-session", 128'(done_o), 128'd0);
    end
    @(negedge clk);
    chk(!done_o, "R9 done single cycle", 128'(done_o), 128'd0);
  endtask

  task automatic err_case(input int bytes, input int cnt);
    @(negedge clk);
    idx_be_i = 64'h1122334455667788; sec_bytes_i = bytes[15:0]; sec_cnt_i = cnt[15:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o && !busy_o && !treq_valid_o, "R8 error pulse",
        128'({err_o, busy_o, treq_valid_o}), 128'b100);
    @(negedge clk);
    chk(!err_o && !treq_valid_o, "R8 error single cycle, no request",
        128'({err_o, treq_valid_o}), 128'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({treq_valid_o, tw_valid_o, done_o, err_o, busy_o} == 5'b0, "R1 reset state",
        128'({treq_valid_o, tw_valid_o, done_o, err_o, busy_o}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({treq_valid_o, tw_valid_o, done_o, err_o, busy_o} == 5'b0, "R1 idle after reset",
        128'({treq_valid_o, tw_valid_o, done_o, err_o, busy_o}), 128'd0);
    // directed: index byte order, single block, partial single sector, multi-sector
    run_session(64'h0100000000000000, 16, 1, 1'b0);
    run_session(64'h0807060504030201, 40, 1, 1'b0);
    run_session(64'hFFFFFFFFFFFFFFFF, 32, 3, 1'b1);
    run_session(64'h00000000000000F0, 512, 2, 1'b0);
    err_case(40, 2);
    err_case(0, 1);
    err_case(64, 0);
    for (int n = 0; n < 10; n++) begin
      run_session({$urandom, $urandom}, 16 * $urandom_range(1, 12),
                  $urandom_range(1, 4), n[0]);
    end
    run_session(64'hA5A5A5A5A5A5A5A5, $urandom_range(1, 15) + 16 * $urandom_range(0, 5), 1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule